// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block turns one active-low external interrupt pin into a request line for a CPU. A small control register picks the pin's sensitivity: either a low level on the pin asserts the request for as long as it lasts, or each falling edge latches a pending flag that holds until the CPU acknowledges it. The register also holds a local enable that gates the request output.

The sensitivity bit is guarded against stray software writes. In normal operating mode only the first write after reset sets it, and later writes leave it alone. In special (test or debug) mode the first write to it is dropped and every later write lands. The enable bit can be written at any time in either mode. The pin is assumed to be synchronized upstream. It idles high when undriven, as if pulled up, so nothing is requested after reset.

Top module: `extint_cond`

## Requirements
- R1: After reset the control register reads 0x40, meaning level sensitivity with the enable set. With the pin high, the request output is 0.
- R2: Bit 6 of the control register is the local enable. Every write updates it, in normal and in special mode, including the first write after reset.
- R3: While the enable bit reads 0, the request output is 0 whatever the pin and the pending flag hold.
- R4: In normal mode (mode_special = 0), the first write after reset loads bit 7 (1 = falling-edge sensitivity, 0 = low-level sensitivity). Later writes leave bit 7 unchanged.
- R5: In special mode (mode_special = 1), the first write after reset leaves bit 7 unchanged. Every later write loads bit 7.
- R6: In level mode with the enable set, the request output equals the inverted pin value in the same cycle.
- R7: In edge mode, a 1-to-0 change of the pin between two clock edges sets a pending flag, and the request output is 1 from the following cycle on. The flag stays set until a cycle with ack = 1. A new falling edge in the same cycle as ack keeps it set.
- R8: Bits 5 to 0 of the control register always read 0, and writes to them have no effect.
- R9: In edge mode, a pin that stays low after an acknowledge does not raise the request again. Only a new falling edge does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_special | input | 1 | 0 = normal mode, 1 = special mode |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control register read value |
| pin_n | input | 1 | Synchronized active-low interrupt pin |
| ack | input | 1 | Clears the pending edge flag |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The bench builds the block with its default parameters: an 8-bit register, the sense bit at position 7 and the enable bit at position 6. It resets the block in each mode in turn, so the first-write rule is seen both accepted and discarded, and the later-write rule both ignored and honoured. A table of pin values exercises level pass-through. Directed sequences cover a held-low pin after an acknowledge, an edge that coincides with an acknowledge, and disabling the enable while an edge is pending.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef struct packed {
        logic sense;       // 1 = edge, 0 = level
        logic enable;
        logic sense_seen;  // a write has already reached the sense bit
    } ctrl_state_t;

    typedef struct packed {
        logic pin_prev;
        logic pending;
    } edge_state_t;

    localparam ctrl_state_t CTRL_RESET = '{sense: 1'b0, enable: 1'b1, sense_seen: 1'b0};
    localparam edge_state_t EDGE_RESET = '{pin_prev: 1'b1, pending: 1'b0};

endpackage

// File: rtl/extint_ctrl_reg.sv
module extint_ctrl_reg
    import extint_pkg::*;
#(
    parameter int REG_W     = 8,
    parameter int SENSE_POS = 7,
    parameter int EN_POS    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_special,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             sense,
    output logic             enable,
    output logic [REG_W-1:0] rd_data
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.enable = wr_data[EN_POS];
            if (!st_q.sense_seen) begin
                st_d.sense_seen = 1'b1;
                // normal mode: first write is the only one taken
                // special mode: first write is dropped
                if (!mode_special) st_d.sense = wr_data[SENSE_POS];
            end else if (mode_special) begin
                st_d.sense = wr_data[SENSE_POS];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data            = '0;
        rd_data[SENSE_POS] = st_q.sense;
        rd_data[EN_POS]    = st_q.enable;
    end

    assign sense  = st_q.sense;
    assign enable = st_q.enable;

endmodule

// File: rtl/extint_edge_det.sv
module extint_edge_det
    import extint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic pin_n,
    input  logic ack,
    output logic pending
);

    edge_state_t st_d, st_q;
    logic        fall;

    always_comb begin
        fall          = st_q.pin_prev & ~pin_n;
        st_d.pin_prev = pin_n;
        // a fresh edge wins over the acknowledge; level mode drops the flag
        st_d.pending  = arm & (fall | (st_q.pending & ~ack));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EDGE_RESET;
        else        st_q <= st_d;
    end

    assign pending = st_q.pending;

endmodule

// File: rtl/extint_req_sel.sv
module extint_req_sel (
    input  logic sense,
    input  logic enable,
    input  logic pending,
    input  logic pin_n,
    output logic irq_req
);

    logic raw_req;

    always_comb begin
        raw_req = sense ? pending : ~pin_n;
        irq_req = enable & raw_req;
    end

endmodule

// File: rtl/extint_cond.sv
module extint_cond #(
    parameter int REG_W     = 8,
    parameter int SENSE_POS = 7,
    parameter int EN_POS    = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_special,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             pin_n,
    input  logic             ack,
    output logic             irq_req
);

    logic sense, enable, pending;

    extint_ctrl_reg #(.REG_W(REG_W), .SENSE_POS(SENSE_POS), .EN_POS(EN_POS)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_special (mode_special),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .sense        (sense),
        .enable       (enable),
        .rd_data      (rd_data)
    );

    extint_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (sense),
        .pin_n   (pin_n),
        .ack     (ack),
        .pending (pending)
    );

    extint_req_sel u_sel (
        .sense   (sense),
        .enable  (enable),
        .pending (pending),
        .pin_n   (pin_n),
        .irq_req (irq_req)
    );

endmodule

// File: rtl/extint_cond_chk.sv
module extint_cond_chk #(
    parameter int REG_W     = 8,
    parameter int SENSE_POS = 7,
    parameter int EN_POS    = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             pin_n,
    input logic             ack,
    input logic             irq_req
);

    logic [REG_W-1:0] used_mask;
    always_comb begin
        used_mask            = '0;
        used_mask[SENSE_POS] = 1'b1;
        used_mask[EN_POS]    = 1'b1;
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[EN_POS] == $past(wr_data[EN_POS])); // R2

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_POS] |-> !irq_req); // R3

    AST_LEVEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[EN_POS] && !rd_data[SENSE_POS]) |-> (irq_req == !pin_n)); // R6

    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[SENSE_POS] && irq_req && !ack && !wr_en) |=> irq_req); // R7

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~used_mask) == '0); // R8

endmodule

bind extint_cond extint_cond_chk #(.REG_W(REG_W), .SENSE_POS(SENSE_POS), .EN_POS(EN_POS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_n   (pin_n),
    .ack     (ack),
    .irq_req (irq_req)
);

// File: tb/extint_cond_test.sv
module extint_cond_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_special = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       pin_n = 1'b1;
    logic       ack = 1'b0;
    logic       irq_req;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    extint_cond uut (
        .clk(clk), .rst_n(rst_n), .mode_special(mode_special),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .pin_n(pin_n), .ack(ack), .irq_req(irq_req)
    );

    // level-mode table: {pin_n, expected irq_req}
    localparam logic [1:0] LVL_VEC [8] = '{
        2'b10, 2'b01, 2'b01, 2'b10, 2'b01, 2'b10, 2'b10, 2'b01
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        step();
        wr_en   = 1'b0;
        #1;
    endtask

    task automatic do_reset(input logic special);
        @(negedge clk);
        rst_n = 1'b0;
        mode_special = special;
        pin_n = 1'b1;
        ack = 1'b0;
        wr_en = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        step();
        #1;
    endtask

    initial begin
        do_reset(1'b0);
        chk("R1 reset value", rd_data, 8'h40);
        chk("R1 idle request", {7'd0, irq_req}, 8'h00);
        chk("R8 spare bits", rd_data & 8'h3F, 8'h00);

        for (int i = 0; i < 8; i++) begin
            pin_n = LVL_VEC[i][1];
            #1;
            chk("R6 level pass", {7'd0, irq_req}, {7'd0, LVL_VEC[i][0]});
            step();
        end
        pin_n = 1'b1;
        step();

        // normal mode: first write sets edge mode, later writes cannot clear it
        write_reg(8'hC0);
        chk("R4 first write", rd_data, 8'hC0);
        write_reg(8'h40);
        chk("R4 later write ignored", rd_data, 8'hC0);
        write_reg(8'h80);
        chk("R2 enable cleared", rd_data, 8'h80);
        write_reg(8'hFF);
        chk("R8 spare writes ignored", rd_data, 8'hC0);

        // edge mode
        pin_n = 1'b0;
        #1;
        chk("R7 no request before edge registers", {7'd0, irq_req}, 8'h00);
        step();
        chk("R7 edge latched", {7'd0, irq_req}, 8'h01);
        step(); step();
        chk("R7 pending held", {7'd0, irq_req}, 8'h01);
        ack = 1'b1;
        step();
        ack = 1'b0;
        #1;
        chk("R9 acked, pin still low", {7'd0, irq_req}, 8'h00);
        step(); step();
        chk("R9 no retrigger on held low", {7'd0, irq_req}, 8'h00);

        pin_n = 1'b1;
        step();
        pin_n = 1'b0;
        step();
        chk("R7 second edge", {7'd0, irq_req}, 8'h01);
        pin_n = 1'b1;
        step();
        pin_n = 1'b0;
        ack = 1'b1;
        step();
        ack = 1'b0;
        #1;
        chk("R7 edge with ack keeps pending", {7'd0, irq_req}, 8'h01);
        write_reg(8'h80);
        chk("R3 disabled with pending", {7'd0, irq_req}, 8'h00);
        write_reg(8'hC0);
        chk("R7 pending survives enable toggle", {7'd0, irq_req}, 8'h01);
        ack = 1'b1;
        step();
        ack = 1'b0;
        #1;
        chk("R7 ack clears", {7'd0, irq_req}, 8'h00);

        // level mode disabled: pin low gives nothing
        do_reset(1'b0);
        write_reg(8'h00);
        pin_n = 1'b0;
        #1;
        chk("R3 level disabled", {7'd0, irq_req}, 8'h00);
        write_reg(8'h40);
        chk("R2 enable set again", {7'd0, irq_req}, 8'h01);
        pin_n = 1'b1;

        // special mode
        do_reset(1'b1);
        chk("R1 reset value special", rd_data, 8'h40);
        write_reg(8'h80);
        chk("R5 first write dropped, R2 enable taken", rd_data, 8'h00);
        write_reg(8'hC0);
        chk("R5 second write taken", rd_data, 8'hC0);
        write_reg(8'h40);
        chk("R5 third write taken", rd_data, 8'h40);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule